// File: doc/BRIEF.md
# Bus-Cycle-Filtered Single-Step Controller

This block sits beside an 8-bit microprocessor that announces each machine cycle on three status outputs (IO/M*, S1, S0) and has a READY input. When the address-latch strobe falls, the block decodes the status lines and compares the cycle type with a chosen trigger. If step mode is on and the cycle matches, the block drops READY in that same clock cycle. It keeps READY low until a single step event arrives. Between matching cycles the processor runs at full speed. A step event comes from a push button, which is synchronised, debounced and edge-detected, or from a slow-step timer that fires at a programmable rate.

The trigger comes from one of two sources. The first is a 3-bit selector code for one of eight choices: any cycle, a cycle class, or an external breakpoint flag. The second is a raw 3-bit status pattern held in a configuration register. A software step-enable bit gates the whole mechanism. The timer period is set by a divide value, so a 50 MHz clock covers about 0.5 Hz to 60 Hz.

Top module: `bus_step_ctrl`

## Requirements
- R1: After reset, `ready` is high, no stall is pending, and the slow-step timer counter is at zero.
- R2: With `trig_src`=0, `trig_sel` picks the trigger. A cycle matches when its {IO/M*,S1,S0} equals the code's pattern: 1 memory write 001, 2 memory read 010, 3 opcode fetch 011, 4 I/O write 101, 5 I/O read 110, 6 interrupt acknowledge 111.
- R3: With `trig_src`=1, a cycle matches only when {IO/M*,S1,S0} equals `trig_pat` exactly. In that case `trig_sel` has no effect.
- R4: Selector code 0 matches every machine cycle. Code 7 matches when `bp_hit` is high in the cycle where ALE falls.
- R5: A falling edge of ALE is seen as ALE high on the previous clock edge and low now. If that cycle matches and `step_en` is high, `ready` goes low in that same clock cycle. It then stays low while no step event arrives.
- R6: A cycle that does not match leaves `ready` high. Status changes that occur without an ALE falling edge have no effect.
- R7: While `step_en` is low, no stall occurs. Clearing `step_en` during a stall drives `ready` high in the same cycle.
- R8: The button input passes two synchroniser flops. It must then hold a new level for `DEB_LIMIT` cycles to be accepted. An accepted rising level produces one single-cycle release pulse. A stalled bus is therefore freed `DEB_LIMIT`+3 clock edges after the button rises, and shorter glitches free nothing.
- R9: While `slow_en` is high, the timer emits a one-cycle release pulse every `slow_div`+1 cycles. While `slow_en` is low, the timer emits none and holds at zero.
- R10: One release pulse ends exactly one stall. `ready` is high from the clock edge that samples the pulse, and a later matching cycle stalls again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ale | input | 1 | Address-latch strobe from the processor |
| st_iom | input | 1 | Status IO/M* line |
| st_s1 | input | 1 | Status S1 line |
| st_s0 | input | 1 | Status S0 line |
| trig_src | input | 1 | 0: use selector code, 1: use raw pattern |
| trig_sel | input | 3 | Selector code (see R2, R4) |
| trig_pat | input | 3 | Raw {IO/M*,S1,S0} trigger pattern |
| bp_hit | input | 1 | External breakpoint-match flag |
| step_en | input | 1 | Software step-mode enable |
| btn_raw | input | 1 | Undebounced step push button, active high |
| slow_en | input | 1 | Slow-step timer enable |
| slow_div | input | DIV_W | Timer divide value; period is value+1 cycles |
| ready | output | 1 | READY to the processor |

## Verification
A stall is due combinationally in the ALE-fall cycle. The bench drives each input just after a rising edge and samples at the falling edge of the same cycle, so it sees that cycle's `ready`. A button release shows `ready` high exactly `DEB_LIMIT`+3 edges after the press is driven, and the bench counts edges to that exact point. Slow-step releases are checked by the spacing between consecutive `ready` rises, which must be `slow_div`+1 cycles. A step-enable clear is checked in the very cycle it is driven.

// File: rtl/bus_step_pkg.sv
package bus_step_pkg;

  typedef enum logic [2:0] {
    SEL_ANY   = 3'd0,
    SEL_MWR   = 3'd1,
    SEL_MRD   = 3'd2,
    SEL_FETCH = 3'd3,
    SEL_IOWR  = 3'd4,
    SEL_IORD  = 3'd5,
    SEL_INTA  = 3'd6,
    SEL_BRK   = 3'd7
  } trig_sel_e;

  // {IO/M*, S1, S0} patterns of each cycle class
  localparam logic [2:0] ST_MWR   = 3'b001;
  localparam logic [2:0] ST_MRD   = 3'b010;
  localparam logic [2:0] ST_FETCH = 3'b011;
  localparam logic [2:0] ST_IOWR  = 3'b101;
  localparam logic [2:0] ST_IORD  = 3'b110;
  localparam logic [2:0] ST_INTA  = 3'b111;

  // Does a cycle with status st match the selector code?
  function automatic logic sel_matches(input trig_sel_e sel, input logic [2:0] st,
                                       input logic bp);
    logic m;
    case (sel)
      SEL_ANY:   m = 1'b1;
      SEL_MWR:   m = (st == ST_MWR);
      SEL_MRD:   m = (st == ST_MRD);
      SEL_FETCH: m = (st == ST_FETCH);
      SEL_IOWR:  m = (st == ST_IOWR);
      SEL_IORD:  m = (st == ST_IORD);
      SEL_INTA:  m = (st == ST_INTA);
      default:   m = bp;
    endcase
    return m;
  endfunction

  // Slow-step period in clock cycles for a given divide value
  function automatic longint unsigned tick_period(input longint unsigned div);
    return div + 1;
  endfunction

endpackage

// File: rtl/status_match.sv
module status_match
  import bus_step_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ale,
  input  logic [2:0] status,
  input  logic       trig_src,
  input  logic [2:0] trig_sel,
  input  logic [2:0] trig_pat,
  input  logic       bp_hit,
  output logic       ale_fall,
  output logic       cyc_hit
);
  logic ale_q;
  logic sel_hit;
  logic pat_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) ale_q <= 1'b0;
    else        ale_q <= ale;
  end

  assign ale_fall = ale_q & ~ale;
  assign sel_hit  = sel_matches(trig_sel_e'(trig_sel), status, bp_hit);
  assign pat_hit  = (status == trig_pat);
  assign cyc_hit  = ale_fall & (trig_src ? pat_hit : sel_hit);

  // R6: no match is reported away from an ALE falling edge
  a_r6_hit_needs_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !ale_fall |-> !cyc_hit);
  // R4: any-cycle selection matches at every falling edge
  a_r4_any_matches: assert property (@(posedge clk) disable iff (!rst_n)
    (ale_fall && !trig_src && trig_sel == 3'd0) |-> cyc_hit);
endmodule

// File: rtl/btn_debounce.sv
module btn_debounce #(
  parameter int DEB_LIMIT = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_raw,
  output logic press_pulse
);
  localparam int CNT_W = $clog2(DEB_LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_LIMIT - 1);

  logic             sync1, sync2;
  logic             level, level_q;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
    end else begin
      sync1 <= btn_raw;
      sync2 <= sync1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      level <= 1'b0;
    end else if (sync2 == level) begin
      cnt <= '0;
    end else if (cnt == CNT_LAST) begin
      cnt   <= '0;
      level <= sync2;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level;
  end

  assign press_pulse = level & ~level_q;

  // R8: a press gives a single-cycle pulse
  a_r8_one_cycle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    press_pulse |=> !press_pulse);
endmodule

// File: rtl/slow_tick.sv
module slow_tick #(
  parameter int DIV_W = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_en,
  input  logic [DIV_W-1:0] slow_div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = slow_en & (cnt >= slow_div);

  always_ff @(posedge clk) begin
    if (!rst_n || !slow_en) cnt <= '0;
    else if (tick)          cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end

  // R9: timer is silent when disabled
  a_r9_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !slow_en |-> !tick);
  // R9: ticks are isolated for divide values above zero
  a_r9_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && slow_div != '0 && $stable(slow_div)) |=> !tick);
endmodule

// File: rtl/bus_step_ctrl.sv
module bus_step_ctrl #(
  parameter int DEB_LIMIT = 50000,
  parameter int DIV_W     = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ale,
  input  logic             st_iom,
  input  logic             st_s1,
  input  logic             st_s0,
  input  logic             trig_src,
  input  logic [2:0]       trig_sel,
  input  logic [2:0]       trig_pat,
  input  logic             bp_hit,
  input  logic             step_en,
  input  logic             btn_raw,
  input  logic             slow_en,
  input  logic [DIV_W-1:0] slow_div,
  output logic             ready
);
  logic ale_fall;
  logic cyc_hit;
  logic press_pulse;
  logic slow_pulse;
  logic step_rel;
  logic stall_req;
  logic stall_q;

  status_match u_match (
    .clk      (clk),
    .rst_n    (rst_n),
    .ale      (ale),
    .status   ({st_iom, st_s1, st_s0}),
    .trig_src (trig_src),
    .trig_sel (trig_sel),
    .trig_pat (trig_pat),
    .bp_hit   (bp_hit),
    .ale_fall (ale_fall),
    .cyc_hit  (cyc_hit)
  );

  btn_debounce #(.DEB_LIMIT(DEB_LIMIT)) u_deb (
    .clk         (clk),
    .rst_n       (rst_n),
    .btn_raw     (btn_raw),
    .press_pulse (press_pulse)
  );

  slow_tick #(.DIV_W(DIV_W)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .slow_en  (slow_en),
    .slow_div (slow_div),
    .tick     (slow_pulse)
  );

  assign stall_req = cyc_hit & step_en;
  assign step_rel  = press_pulse | slow_pulse;

  always_ff @(posedge clk) begin
    if (!rst_n) stall_q <= 1'b0;
    else        stall_q <= step_en & (stall_req | (stall_q & ~step_rel));
  end

  assign ready = ~((stall_q & step_en) | stall_req);

  // R5: a matching falling edge drops READY in its own cycle
  a_r5_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (ale_fall && cyc_hit && step_en) |-> !ready);
  // R5: the stall persists without a step event
  a_r5_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !step_rel && step_en) |=> (!ready || !step_en));
  // R7: step mode off means full speed
  a_r7_off_runs: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |-> ready);
  // R10: one release ends the stall
  a_r10_release_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_q && step_rel && !ale_fall) |=> !stall_q);
endmodule

// File: tb/bus_step_ctrl_tb.sv
module bus_step_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEB        = 4;
  localparam int DW         = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ale = 1'b0, st_iom = 1'b0, st_s1 = 1'b0, st_s0 = 1'b0;
  logic trig_src = 1'b0;
  logic [2:0] trig_sel = 3'd0, trig_pat = 3'd0;
  logic bp_hit = 1'b0, step_en = 1'b0, btn_raw = 1'b0, slow_en = 1'b0;
  logic [DW-1:0] slow_div = '0;
  logic ready;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  bus_step_ctrl #(.DEB_LIMIT(DEB), .DIV_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ale(ale), .st_iom(st_iom), .st_s1(st_s1),
    .st_s0(st_s0), .trig_src(trig_src), .trig_sel(trig_sel), .trig_pat(trig_pat),
    .bp_hit(bp_hit), .step_en(step_en), .btn_raw(btn_raw), .slow_en(slow_en),
    .slow_div(slow_div), .ready(ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic bit want_stall(bit src, bit [2:0] sel, bit [2:0] pat,
                                    bit [2:0] st, bit bp, bit en);
    bit m;
    if (!en) return 0;
    if (src) return st == pat;
    case (sel)
      3'd0: m = 1;
      3'd1: m = (st == 3'b001);
      3'd2: m = (st == 3'b010);
      3'd3: m = (st == 3'b011);
      3'd4: m = (st == 3'b101);
      3'd5: m = (st == 3'b110);
      3'd6: m = (st == 3'b111);
      default: m = bp;
    endcase
    return m;
  endfunction

  task automatic check(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: ready=%b expected=%b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic check_int(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step_clk();
    @(posedge clk); #1;
  endtask

  // ALE high one cycle, then falls; returns ready seen in the fall cycle
  task automatic bus_cycle(bit [2:0] st, bit bp, output logic rdy);
    ale = 1; {st_iom, st_s1, st_s0} = st; bp_hit = bp;
    step_clk();
    ale = 0;
    @(negedge clk); rdy = ready;
    step_clk();
    bp_hit = 0;
  endtask

  // press button; returns edges until ready high (cap 40)
  task automatic press(output int edges);
    edges = 0;
    btn_raw = 1;
    while (edges < 40) begin
      @(posedge clk); edges++;
      @(negedge clk);
      if (ready) break;
    end
    #1;
    repeat (DEB + 4) step_clk();
    btn_raw = 0;
    repeat (DEB + 4) step_clk();
  endtask

  initial begin
    logic r;
    int e, t1, t2;
    repeat (3) step_clk();
    rst_n = 1;
    @(negedge clk);
    check("R1 reset ready", ready, 1'b1);
    step_clk();
    step_en = 1;

    // R2 directed: I/O write selector
    trig_sel = 3'd4;
    bus_cycle(3'b110, 0, r); check("R2 io read vs io write sel", r, 1'b1);
    bus_cycle(3'b101, 0, r); check("R2 io write stalls", r, 1'b0);
    @(negedge clk); check("R5 still low next cycle", ready, 1'b0);
    #1;
    // R6: status toggle without ALE
    {st_iom, st_s1, st_s0} = 3'b000; step_clk(); step_clk();
    @(negedge clk); check("R6 status change no ALE", ready, 1'b0);
    #1;
    // R8 glitch rejected
    btn_raw = 1; repeat (DEB - 2) step_clk(); btn_raw = 0;
    repeat (DEB + 4) step_clk();
    @(negedge clk); check("R8 glitch ignored", ready, 1'b0);
    #1;
    press(e); check_int("R8 release latency", e, DEB + 3);
    @(negedge clk); check("R10 free after one release", ready, 1'b1);
    #1;

    // R4 breakpoint and any
    trig_sel = 3'd7;
    bus_cycle(3'b011, 0, r); check("R4 brk without flag", r, 1'b1);
    bus_cycle(3'b011, 1, r); check("R4 brk with flag", r, 1'b0);
    press(e);
    trig_sel = 3'd0;
    bus_cycle(3'b000, 0, r); check("R4 any cycle", r, 1'b0);
    // R10: button held long frees only this stall; next cycle stalls again
    press(e);
    bus_cycle(3'b010, 0, r); check("R10 next match stalls again", r, 1'b0);
    // R7 clearing step_en frees in same cycle
    step_en = 0;
    @(negedge clk); check("R7 clear frees at once", ready, 1'b1);
    #1;
    bus_cycle(3'b011, 0, r); check("R7 no stall when off", r, 1'b1);
    step_en = 1;

    // R3 raw pattern source
    trig_src = 1; trig_pat = 3'b100; trig_sel = 3'd0;
    bus_cycle(3'b101, 0, r); check("R3 pattern mismatch ignores sel", r, 1'b1);
    bus_cycle(3'b100, 0, r); check("R3 pattern exact match", r, 1'b0);
    press(e);
    trig_src = 0;

    // R9 slow step timing
    slow_div = 8'd5; trig_sel = 3'd0; slow_en = 1;
    bus_cycle(3'b011, 0, r);
    while (!ready) begin @(negedge clk); #1; end
    t1 = cyc;
    for (int k = 0; k < 3; k++) begin
      bus_cycle(3'b011, 0, r);
      check("R9 slow stall", r, 1'b0);
      while (1) begin @(negedge clk); if (ready) break; end
      t2 = cyc;
      check_int("R9 tick spacing", t2 - t1, 6);
      t1 = t2;
      #1;
    end
    slow_en = 0;
    bus_cycle(3'b011, 0, r);
    repeat (20) step_clk();
    @(negedge clk); check("R9 no ticks when off", ready, 1'b0);
    #1;
    press(e);

    // random mix, released by button
    void'($urandom(32'h5eed));
    for (int i = 0; i < 60; i++) begin
      bit [2:0] st, sel, pat;
      bit bp, src, ex;
      st = 3'($urandom); sel = 3'($urandom); pat = 3'($urandom);
      bp = 1'($urandom); src = ($urandom % 4) == 0;
      trig_sel = sel; trig_pat = pat; trig_src = src;
      ex = want_stall(src, sel, pat, st, bp, 1'b1);
      bus_cycle(st, bp, r);
      check("R2 random match", r, !ex);
      if (ex) begin
        press(e); check_int("R8 random latency", e, DEB + 3);
      end
    end
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule